// File: doc/BRIEF.md
# Row-Sequential Pixel Matrix Readout Sequencer

This block drives the row-select lines of a pixel matrix whose rows are read one at a time while every column is digitised in parallel. For the selected row it turns the row gate on, waits a settling time, strobes the signal sampler, then fires the row's charge-clear line together with its clear-barrier line. Next it strobes the baseline sampler, turns the gate off and moves to the next row. Each pixel value is the signal sample minus the baseline sample, computed for all columns at once and published with a row-valid strobe.

Rows are visited in ascending order and wrap after the last one, so each row integrates charge for as long as all the other rows take to read. A frame-start pulse marks the beginning of row 0. An optional reference mode inserts an extra clear just before the signal sample, which removes almost all of the leakage charge collected during integration. The settle, sample-window and clear-pulse lengths are cycle counts taken from inputs when the sequencer leaves the idle state.

Top module: `rowseq_readout`

## Requirements
- R1: At any cycle at most one bit of `gate_o` is high, and bit i belongs to row i.
- R2: For each row the gate is held high through these windows in order: settle for `cfg_settle_i`+1 cycles, signal window for `cfg_sample_i`+1 cycles, clear for `cfg_clear_i`+1 cycles, baseline window for `cfg_sample_i`+1 cycles. These are followed by exactly one cycle with every gate line low.
- R3: `sig_strobe_o` is high only in the last cycle of the signal window and `base_strobe_o` only in the last cycle of the baseline window. The column data present in that cycle is the value sampled.
- R4: In the cycle after the baseline strobe, `row_valid_o` is high for one cycle, and field c of `diff_o` (bits [c*(SAMPLE_W+1) +: SAMPLE_W+1]) holds signal minus baseline of column c as an unsigned-input, two's complement result.
- R5: `clr_o` and `clrgate_o` are high together and only on the bit of the row whose gate is on, during the clear windows. They are never high while the gate of a different row is on.
- R6: Rows advance 0,1,...,N_ROWS-1 and then wrap to 0. `row_idx_o` names the row whose difference is valid. `frame_start_o` is high in the first settle cycle of row 0.
- R7: With reference mode latched, a pre-clear window of `cfg_clear_i`+1 cycles, with clear and clear-barrier on, sits between the settle window and the signal window.
- R8: The three counts and the reference-mode select are taken only when leaving idle. Changing them while running has no effect on the sequence.
- R9: When `run_i` is low at the end of a row's gate-off cycle, the sequencer goes idle. The next start begins again at row 0.
- R10: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Start from idle; keep high to continue row after row |
| ref_mode_i | input | 1 | Select reference mode (pre-clear) |
| cfg_settle_i | input | CNT_W | Settle window length minus one |
| cfg_sample_i | input | CNT_W | Sample window length minus one |
| cfg_clear_i | input | CNT_W | Clear pulse length minus one |
| col_data_i | input | N_COLS*SAMPLE_W | Parallel column samples, column c at [c*SAMPLE_W +: SAMPLE_W] |
| gate_o | output | N_ROWS | Per-row gate enable |
| clr_o | output | N_ROWS | Per-row clear pulse |
| clrgate_o | output | N_ROWS | Per-row clear-barrier pulse |
| sig_strobe_o | output | 1 | Signal sampler strobe |
| base_strobe_o | output | 1 | Baseline sampler strobe |
| frame_start_o | output | 1 | First cycle of row 0 |
| row_valid_o | output | 1 | Column differences valid |
| row_idx_o | output | $clog2(N_ROWS) | Row of the valid differences |
| diff_o | output | N_COLS*(SAMPLE_W+1) | Per-column signed difference |

## Verification
The bench targets the wrap from the last row to row 0. A design that got it wrong would skip row 0, raise the frame marker on the wrong row, or run past the matrix edge. It also exercises zero-length windows, where an off-by-one design would drop or double a strobe. It checks that reference mode places the pre-clear ahead of the signal sample; a misplaced pre-clear would leave leakage in the difference. It changes the configuration mid-frame, which a design that reloads early would obey, and it drops `run_i` mid-row, where a faulty design would cut a row short or restart from the wrong row. Column data changes every cycle, so a sample captured one cycle off, or a subtraction with its operands swapped, shows up as a wrong difference.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETTLE = 3'd1,
        PH_PRECLR = 3'd2,
        PH_SIG    = 3'd3,
        PH_CLR    = 3'd4,
        PH_BASE   = 3'd5,
        PH_OFF    = 3'd6
    } phase_e;
endpackage

// File: rtl/rowseq_fsm.sv
module rowseq_fsm
    import rowseq_pkg::*;
#(
    parameter int N_ROWS = 64,
    parameter int CNT_W  = 8,
    localparam int ROW_W = $clog2(N_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             ref_mode_i,
    input  logic [CNT_W-1:0] cfg_settle_i,
    input  logic [CNT_W-1:0] cfg_sample_i,
    input  logic [CNT_W-1:0] cfg_clear_i,
    output phase_e           phase_o,
    output logic             last_o,
    output logic [ROW_W-1:0] row_o,
    output logic             frame_start_o,
    output logic             row_valid_o,
    output logic [ROW_W-1:0] valid_row_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_ROWS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] settle;
        logic [CNT_W-1:0] sample;
        logic [CNT_W-1:0] clear;
        logic             refm;
        logic             frame;
        logic             valid;
        logic [ROW_W-1:0] vrow;
    } fsm_t;

    fsm_t st_d, st_q;
    logic at_end;

    always_comb begin
        st_d       = st_q;
        st_d.frame = 1'b0;
        st_d.valid = 1'b0;
        at_end     = (st_q.cnt == '0);
        unique case (st_q.phase)
            PH_IDLE: begin
                if (run_i) begin
                    st_d.settle = cfg_settle_i;
                    st_d.sample = cfg_sample_i;
                    st_d.clear  = cfg_clear_i;
                    st_d.refm   = ref_mode_i;
                    st_d.phase  = PH_SETTLE;
                    st_d.cnt    = cfg_settle_i;
                    st_d.row    = '0;
                    st_d.frame  = 1'b1;
                end
            end
            PH_SETTLE: begin
                if (!at_end) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (st_q.refm) begin
                    st_d.phase = PH_PRECLR;
                    st_d.cnt   = st_q.clear;
                end else begin
                    st_d.phase = PH_SIG;
                    st_d.cnt   = st_q.sample;
                end
            end
            PH_PRECLR: begin
                if (!at_end) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.phase = PH_SIG;
                    st_d.cnt   = st_q.sample;
                end
            end
            PH_SIG: begin
                if (!at_end) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.phase = PH_CLR;
                    st_d.cnt   = st_q.clear;
                end
            end
            PH_CLR: begin
                if (!at_end) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.phase = PH_BASE;
                    st_d.cnt   = st_q.sample;
                end
            end
            PH_BASE: begin
                if (!at_end) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.phase = PH_OFF;
                    st_d.cnt   = '0;
                    st_d.valid = 1'b1;
                    st_d.vrow  = st_q.row;
                end
            end
            PH_OFF: begin
                if (run_i) begin
                    st_d.phase = PH_SETTLE;
                    st_d.cnt   = st_q.settle;
                    if (st_q.row == LAST_ROW) begin
                        st_d.row   = '0;
                        st_d.frame = 1'b1;
                    end else begin
                        st_d.row = st_q.row + ROW_W'(1);
                    end
                end else begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o       = st_q.phase;
    assign last_o        = (st_q.cnt == '0);
    assign row_o         = st_q.row;
    assign frame_start_o = st_q.frame;
    assign row_valid_o   = st_q.valid;
    assign valid_row_o   = st_q.vrow;
endmodule

// File: rtl/rowseq_rowdrv.sv
module rowseq_rowdrv #(
    parameter int N_ROWS = 64,
    localparam int ROW_W = $clog2(N_ROWS)
) (
    input  logic [ROW_W-1:0]  row_i,
    input  logic              gate_en_i,
    input  logic              clr_en_i,
    output logic [N_ROWS-1:0] gate_o,
    output logic [N_ROWS-1:0] clr_o,
    output logic [N_ROWS-1:0] clrgate_o
);
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        logic hit;
        assign hit          = (row_i == ROW_W'(r));
        assign gate_o[r]    = gate_en_i & hit;
        assign clr_o[r]     = clr_en_i & hit;
        assign clrgate_o[r] = clr_en_i & hit;
    end
endmodule

// File: rtl/rowseq_coldiff.sv
module rowseq_coldiff #(
    parameter int N_COLS   = 64,
    parameter int SAMPLE_W = 12,
    localparam int DIFF_W  = SAMPLE_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sig_cap_i,
    input  logic                       base_cap_i,
    input  logic [N_COLS*SAMPLE_W-1:0] col_data_i,
    output logic [N_COLS*DIFF_W-1:0]   diff_o
);
    typedef struct packed {
        logic [N_COLS*SAMPLE_W-1:0] sig;
        logic [N_COLS*DIFF_W-1:0]   diff;
    } col_t;

    col_t cs_d, cs_q;
    logic [N_COLS*DIFF_W-1:0] sub_w;

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        assign sub_w[c*DIFF_W +: DIFF_W] =
            {1'b0, cs_q.sig[c*SAMPLE_W +: SAMPLE_W]} -
            {1'b0, col_data_i[c*SAMPLE_W +: SAMPLE_W]};
    end

    always_comb begin
        cs_d = cs_q;
        if (sig_cap_i) begin
            cs_d.sig = col_data_i;
        end
        if (base_cap_i) begin
            cs_d.diff = sub_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign diff_o = cs_q.diff;
endmodule

// File: rtl/rowseq_readout.sv
module rowseq_readout
    import rowseq_pkg::*;
#(
    parameter int N_ROWS   = 64,
    parameter int N_COLS   = 64,
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 8,
    localparam int ROW_W   = $clog2(N_ROWS),
    localparam int DIFF_W  = SAMPLE_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_i,
    input  logic                       ref_mode_i,
    input  logic [CNT_W-1:0]           cfg_settle_i,
    input  logic [CNT_W-1:0]           cfg_sample_i,
    input  logic [CNT_W-1:0]           cfg_clear_i,
    input  logic [N_COLS*SAMPLE_W-1:0] col_data_i,
    output logic [N_ROWS-1:0]          gate_o,
    output logic [N_ROWS-1:0]          clr_o,
    output logic [N_ROWS-1:0]          clrgate_o,
    output logic                       sig_strobe_o,
    output logic                       base_strobe_o,
    output logic                       frame_start_o,
    output logic                       row_valid_o,
    output logic [ROW_W-1:0]           row_idx_o,
    output logic [N_COLS*DIFF_W-1:0]   diff_o
);
    phase_e           phase_w;
    logic             last_w;
    logic [ROW_W-1:0] row_w;
    logic             gate_en_w;
    logic             clr_en_w;

    rowseq_fsm #(.N_ROWS(N_ROWS), .CNT_W(CNT_W)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run_i),
        .ref_mode_i    (ref_mode_i),
        .cfg_settle_i  (cfg_settle_i),
        .cfg_sample_i  (cfg_sample_i),
        .cfg_clear_i   (cfg_clear_i),
        .phase_o       (phase_w),
        .last_o        (last_w),
        .row_o         (row_w),
        .frame_start_o (frame_start_o),
        .row_valid_o   (row_valid_o),
        .valid_row_o   (row_idx_o)
    );

    assign gate_en_w = (phase_w == PH_SETTLE) || (phase_w == PH_PRECLR) ||
                       (phase_w == PH_SIG)    || (phase_w == PH_CLR)    ||
                       (phase_w == PH_BASE);
    assign clr_en_w  = (phase_w == PH_PRECLR) || (phase_w == PH_CLR);
    assign sig_strobe_o  = (phase_w == PH_SIG)  && last_w;
    assign base_strobe_o = (phase_w == PH_BASE) && last_w;

    rowseq_rowdrv #(.N_ROWS(N_ROWS)) drv_i (
        .row_i     (row_w),
        .gate_en_i (gate_en_w),
        .clr_en_i  (clr_en_w),
        .gate_o    (gate_o),
        .clr_o     (clr_o),
        .clrgate_o (clrgate_o)
    );

    rowseq_coldiff #(.N_COLS(N_COLS), .SAMPLE_W(SAMPLE_W)) col_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_cap_i  (sig_strobe_o),
        .base_cap_i (base_strobe_o),
        .col_data_i (col_data_i),
        .diff_o     (diff_o)
    );
endmodule

// File: rtl/rowseq_checker.sv
module rowseq_checker #(
    parameter int N_ROWS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_ROWS-1:0] gate_o,
    input logic [N_ROWS-1:0] clr_o,
    input logic [N_ROWS-1:0] clrgate_o,
    input logic              sig_strobe_o,
    input logic              base_strobe_o,
    input logic              frame_start_o,
    input logic              row_valid_o
);
    a_r1_onehot_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_o));

    a_r5_clear_own_row: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> (clr_o == gate_o));

    a_r5_barrier_own_row: assert property (@(posedge clk) disable iff (!rst_n)
        (|clrgate_o) |-> (clrgate_o == gate_o));

    a_r4_valid_after_base: assert property (@(posedge clk) disable iff (!rst_n)
        base_strobe_o |=> row_valid_o);

    a_r2_gate_off_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid_o |-> (gate_o == '0));

    a_r3_strobe_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_strobe_o || base_strobe_o) |-> ((|gate_o) && !(|clr_o)));

    a_r6_frame_on_row0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> gate_o[0]);
endmodule

bind rowseq_readout rowseq_checker #(.N_ROWS(N_ROWS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .gate_o        (gate_o),
    .clr_o         (clr_o),
    .clrgate_o     (clrgate_o),
    .sig_strobe_o  (sig_strobe_o),
    .base_strobe_o (base_strobe_o),
    .frame_start_o (frame_start_o),
    .row_valid_o   (row_valid_o)
);

// File: tb/rowseq_readout_tb_top.sv
module rowseq_readout_tb_top;
    localparam int NR = 64;
    localparam int NC = 64;
    localparam int SW = 12;
    localparam int CW = 8;
    localparam int RW = $clog2(NR);
    localparam int DW = SW + 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              run;
    logic              refm;
    logic [CW-1:0]     c_set, c_smp, c_clr;
    logic [NC*SW-1:0]  col_data;
    logic [NR-1:0]     gate, clr, clrg;
    logic              sstb, bstb, fstart, rvalid;
    logic [RW-1:0]     ridx;
    logic [NC*DW-1:0]  diff;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit live   = 0;

    always #2 clk = ~clk;

    rowseq_readout dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .ref_mode_i(refm),
        .cfg_settle_i(c_set), .cfg_sample_i(c_smp), .cfg_clear_i(c_clr),
        .col_data_i(col_data), .gate_o(gate), .clr_o(clr), .clrgate_o(clrg),
        .sig_strobe_o(sstb), .base_strobe_o(bstb), .frame_start_o(fstart),
        .row_valid_o(rvalid), .row_idx_o(ridx), .diff_o(diff)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference: phase 0 idle,1 settle,2 preclear,3 signal,4 clear,5 baseline,6 off
    int m_ph = 0, m_left = 0, m_row = 0, m_vrow = 0;
    int m_set = 0, m_smp = 0, m_clr = 0;
    bit m_ref = 0, m_frame = 0, m_valid = 0;
    int m_sig [NC];
    int m_diff[NC];

    function automatic int colv(input logic [NC*SW-1:0] v, input int c);
        return int'(v[c*SW +: SW]);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_frame = 0; m_valid = 0;
        end else begin
            m_frame = 0;
            m_valid = 0;
            case (m_ph)
                0: if (run) begin
                    m_set = c_set; m_smp = c_smp; m_clr = c_clr; m_ref = refm;
                    m_ph = 1; m_left = m_set; m_row = 0; m_frame = 1;
                end
                6: if (run) begin
                    m_row = (m_row + 1) % NR;
                    m_frame = (m_row == 0);
                    m_ph = 1; m_left = m_set;
                end else m_ph = 0;
                default: if (m_left > 0) m_left--;
                else begin
                    case (m_ph)
                        1: if (m_ref) begin m_ph = 2; m_left = m_clr; end
                           else begin m_ph = 3; m_left = m_smp; end
                        2: begin m_ph = 3; m_left = m_smp; end
                        3: begin
                            for (int c = 0; c < NC; c++) m_sig[c] = colv(col_data, c);
                            m_ph = 4; m_left = m_clr;
                        end
                        4: begin m_ph = 5; m_left = m_smp; end
                        default: begin
                            for (int c = 0; c < NC; c++) m_diff[c] = m_sig[c] - colv(col_data, c);
                            m_valid = 1; m_vrow = m_row; m_ph = 6;
                        end
                    endcase
                end
            endcase
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (live) begin
            logic [NR-1:0] eg, ec;
            eg = (m_ph >= 1 && m_ph <= 5) ? (NR'(1) << m_row) : '0;
            ec = (m_ph == 2 || m_ph == 4) ? (NR'(1) << m_row) : '0;
            chk(gate == eg, "R1/R2", "gate lines", gate, eg);
            chk(clr == ec, m_ph == 2 ? "R7" : "R5", "clear lines", clr, ec);
            chk(clrg == ec, "R5", "clear-barrier lines", clrg, ec);
            chk(sstb == (m_ph == 3 && m_left == 0), "R3", "signal strobe", sstb, (m_ph == 3 && m_left == 0));
            chk(bstb == (m_ph == 5 && m_left == 0), "R3", "baseline strobe", bstb, (m_ph == 5 && m_left == 0));
            chk(fstart == m_frame, "R6", "frame start", fstart, m_frame);
            chk(rvalid == m_valid, "R4", "row valid", rvalid, m_valid);
            if (m_valid) begin
                bit ok = 1;
                int bad = 0;
                for (int c = NC - 1; c >= 0; c--)
                    if (int'($signed(diff[c*DW +: DW])) != m_diff[c]) begin ok = 0; bad = c; end
                chk(ok, "R4", "column difference",
                    longint'($signed(diff[bad*DW +: DW])), longint'(m_diff[bad]));
                chk(ridx == RW'(m_vrow), "R6", "row index", ridx, m_vrow);
            end
        end
    end

    // Column stimulus changes every cycle
    always @(negedge clk) begin
        for (int c = 0; c < NC; c++)
            col_data[c*SW +: SW] <= SW'((c * 37 + cyc * 11 + 5) % 4096);
    end

    task automatic go(input int s, input int sm, input int cl, input bit rf,
                      input int cycles, input bit poke);
        @(negedge clk);
        c_set = CW'(s); c_smp = CW'(sm); c_clr = CW'(cl); refm = rf; run = 1'b1;
        repeat (cycles / 2) @(negedge clk);
        if (poke) begin   // R8: mid-run changes must be ignored
            c_set = CW'(s + 3); c_smp = CW'(sm + 2); c_clr = CW'(cl + 1); refm = ~rf;
        end
        repeat (cycles / 2) @(negedge clk);
        run = 1'b0;
        repeat (40) @(negedge clk);
        // R9: back to idle, all lines quiet
        chk(gate == '0 && clr == '0 && !sstb && !bstb, "R9", "idle after run low",
            {gate, 3'(0)}, 0);
    endtask

    initial begin
        rst_n = 1'b0; run = 1'b0; refm = 1'b0;
        c_set = '0; c_smp = '0; c_clr = '0;
        repeat (4) @(negedge clk);
        chk(gate == '0, "R10", "reset gate", gate, 0);
        chk(clr == '0 && clrg == '0, "R10", "reset clear", clr, 0);
        chk(!sstb && !bstb && !fstart && !rvalid, "R10", "reset strobes",
            {sstb, bstb, fstart, rvalid}, 0);
        chk(diff == '0 && ridx == '0, "R10", "reset data", ridx, 0);
        rst_n = 1'b1;
        live  = 1'b1;
        go(1, 1, 2, 1'b0, 1400, 1'b1);   // two frames, wrap, R8 poke
        go(0, 2, 0, 1'b1, 300, 1'b0);    // R7 reference mode
        go(3, 0, 1, 1'b0, 700, 1'b1);    // zero-length sample window, restart at row 0
        go(0, 0, 0, 1'b1, 500, 1'b0);    // all minimum windows
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule